// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit

This block computes one of four signed saturating operations on two signed operands of the same width. The four operations are add, subtract, add of a doubled second operand, and subtract of a doubled second operand. The result is combinational. When the true value does not fit in the signed range, the result is clamped to the nearest end of that range instead of wrapping. The doubled forms clamp twice. The second operand is first doubled and clamped. That clamped value is then added to or subtracted from the first operand, and the sum is clamped again.

A registered sticky overflow flag records that at least one accepted operation saturated in its final stage. An operation is accepted on a cycle where the valid strobe is high. Later non-saturating operations never lower the flag. After a run of operations, the flag shows only that some operation in the run overflowed, not which one. A dedicated clear input lowers the flag and wins over a set in the same cycle. The block drives no ordinary condition codes.

Top module: `sat_arith_unit`

## Requirements
- R1: With opSel = 2'b00, result is opA + opB. It clamps to the signed maximum (0x7FFFFFFF at 32 bits) on positive overflow and to the signed minimum (0x80000000) on negative overflow.
- R2: With opSel = 2'b01, result is opA - opB, clamped the same way. Subtracting the signed minimum gives the correct clamped or exact value.
- R3: With opSel = 2'b10, result is SAT(opA + SAT(2*opB)). The doubled operand is clamped before the addition.
- R4: With opSel = 2'b11, result is SAT(opA - SAT(2*opB)), using the same two-stage clamping.
- R5: A clamped result is exactly the signed maximum for positive overflow and exactly the signed minimum for negative overflow. No wrapped value ever appears.
- R6: When inValid is high and the final add or subtract stage saturates, qSticky reads 1 from the next clock edge on.
- R7: Once set, qSticky stays 1 through later accepted operations that do not overflow.
- R8: qClear high at a clock edge makes qSticky 0 after that edge, even if an overflowing accepted operation is present in the same cycle.
- R9: With inValid low, an overflowing operation on the inputs leaves qSticky unchanged.
- R10: After reset (rstN low), qSticky is 0.
- R11: Saturation of the doubling stage alone does not set qSticky. For example, opA = 0xFFFFFFFF, opB = 0x40000000, opSel = 2'b10 gives 0x7FFFFFFE and leaves qSticky at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sticky flag |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | DATA_W | First signed operand |
| opB | input | DATA_W | Second signed operand (doubled in the doubled operations) |
| opSel | input | 2 | 00 add, 01 subtract, 10 doubled add, 11 doubled subtract |
| inValid | input | 1 | Operation accepted for flag update this cycle |
| qClear | input | 1 | Clears the sticky flag; has priority over a set |
| result | output | DATA_W | Saturated result (combinational) |
| qSticky | output | 1 | Sticky overflow flag |

## Verification
The bench builds the unit at its default DATA_W of 32. At that width the table can use the exact boundary values 0x7FFFFFFF, 0x80000000 and 0x40000000. These values bring three cases within reach: doubling the most negative operand, doubling 0x40000000 into a clamp whose final sum does not overflow, and subtracting the most negative value. Each table row also holds the expected flag state. The flag is cleared before every row, so the flag check isolates the overflow of that single row. Directed sequences then exercise stickiness, the ignored-when-invalid case and the priority of clear over set.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;

  // Strobes the control hands to the datapath
  typedef struct packed {
    logic useDouble;   // double and clamp opB before the final stage
    logic doSubtract;  // final stage subtracts instead of adds
  } sat_strobe_t;

endpackage

// File: rtl/sat_clamp.sv
// Clamps a one-bit-extended signed value back into DATA_W bits.
module sat_clamp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W:0]   wideVal,
  output logic [DATA_W-1:0] clampVal,
  output logic              clamped
);
  localparam logic [DATA_W-1:0] MAX_VAL = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_VAL = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    clamped = wideVal[DATA_W] ^ wideVal[DATA_W-1];
    if (!clamped)           clampVal = wideVal[DATA_W-1:0];
    else if (wideVal[DATA_W]) clampVal = MIN_VAL;
    else                    clampVal = MAX_VAL;
  end
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_arith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  sat_strobe_t       strobe,
  output logic [DATA_W-1:0] result,
  output logic              finalOvf
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0]  dblWide;
  logic [DATA_W-1:0] dblSat;
  logic              dblClamped;
  logic [DATA_W-1:0] secondOp;
  logic [EXT_W-1:0]  extA;
  logic [EXT_W-1:0]  extB;
  logic [EXT_W-1:0]  sumWide;

  // Doubling stage: a left shift into EXT_W bits is exact
  assign dblWide = {opB, 1'b0};

  sat_clamp #(.DATA_W(DATA_W)) u_dblClamp (
    .wideVal (dblWide),
    .clampVal(dblSat),
    .clamped (dblClamped)
  );

  assign secondOp = strobe.useDouble ? dblSat : opB;
  assign extA     = {opA[DATA_W-1], opA};
  assign extB     = {secondOp[DATA_W-1], secondOp};
  assign sumWide  = strobe.doSubtract ? (extA - extB) : (extA + extB);

  // Final stage: only its clamp is reported as overflow
  sat_clamp #(.DATA_W(DATA_W)) u_sumClamp (
    .wideVal (sumWide),
    .clampVal(result),
    .clamped (finalOvf)
  );

  logic unusedDbl;
  assign unusedDbl = dblClamped;
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_arith_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  opSel,
  input  logic        inValid,
  input  logic        qClear,
  input  logic        finalOvf,
  output sat_strobe_t strobe,
  output logic        qSticky
);
  sat_op_e opCode;

  always_comb begin
    opCode = sat_op_e'(opSel);
    strobe = '0;
    unique case (opCode)
      OP_ADD:  strobe = '{useDouble: 1'b0, doSubtract: 1'b0};
      OP_SUB:  strobe = '{useDouble: 1'b0, doSubtract: 1'b1};
      OP_DADD: strobe = '{useDouble: 1'b1, doSubtract: 1'b0};
      OP_DSUB: strobe = '{useDouble: 1'b1, doSubtract: 1'b1};
      default: strobe = '0;
    endcase
  end

  // Sticky flag: clear wins, set only on accepted overflow
  always_ff @(posedge clk) begin
    if (!rstN)                     qSticky <= 1'b0;
    else if (qClear)               qSticky <= 1'b0;
    else if (inValid && finalOvf)  qSticky <= 1'b1;
  end
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
  import sat_arith_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [1:0]        opSel,
  input  logic              inValid,
  input  logic              qClear,
  output logic [DATA_W-1:0] result,
  output logic              qSticky
);
  sat_strobe_t strobe;
  logic        finalOvf;

  sat_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .opSel   (opSel),
    .inValid (inValid),
    .qClear  (qClear),
    .finalOvf(finalOvf),
    .strobe  (strobe),
    .qSticky (qSticky)
  );

  sat_datapath #(.DATA_W(DATA_W)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (result),
    .finalOvf(finalOvf)
  );
endmodule

// File: rtl/sat_arith_checker.sv
module sat_arith_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [1:0]        opSel,
  input logic              inValid,
  input logic              qClear,
  input logic [DATA_W-1:0] result,
  input logic              qSticky
);
  localparam int MSB = DATA_W - 1;

  AST_ADD_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b00 && opA[MSB] == opB[MSB]) |-> (result[MSB] == opA[MSB])); // R1
  AST_SUB_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b01 && opA[MSB] != opB[MSB]) |-> (result[MSB] == opA[MSB])); // R2
  AST_DADD_NEG_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (opSel == 2'b10 && opA[MSB] && opB[MSB]) |-> result[MSB]); // R3
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (qSticky && !qClear) |=> qSticky); // R7
  AST_Q_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    qClear |=> !qSticky); // R8
  AST_Q_HOLD_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !qClear) |=> $stable(qSticky)); // R9
endmodule

bind sat_arith_unit sat_arith_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_sat_arith_unit.sv
module tb_sat_arith_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
    logic        ovf;
  } vec_t;

  // op, a, b, expected result, expected flag after one accepted op
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0},  // R1
    '{2'd0, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},  // R1 R5
    '{2'd0, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},  // R1 R5
    '{2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 1'b0},  // R1
    '{2'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0},  // R2
    '{2'd1, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1},  // R2 R5
    '{2'd1, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1},  // R2 R5
    '{2'd1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b0},  // R2 exact
    '{2'd2, 32'h0000000A, 32'h00000003, 32'h00000010, 1'b0},  // R3
    '{2'd2, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0},  // R3 R11
    '{2'd2, 32'hFFFFFFFF, 32'h40000000, 32'h7FFFFFFE, 1'b0},  // R3 R11
    '{2'd2, 32'h00000001, 32'h40000000, 32'h7FFFFFFF, 1'b1},  // R3 R5
    '{2'd2, 32'hFFFFFFFF, 32'h80000000, 32'h80000000, 1'b1},  // R3 R5
    '{2'd3, 32'h00000000, 32'h40000000, 32'h80000001, 1'b0},  // R4 R11
    '{2'd3, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b0},  // R4 R11
    '{2'd3, 32'h00000000, 32'h80000000, 32'h7FFFFFFF, 1'b1},  // R4 R5
    '{2'd3, 32'h00000064, 32'h00000014, 32'h0000003C, 1'b0},  // R4
    '{2'd3, 32'h80000000, 32'h00000001, 32'h80000000, 1'b1}   // R4 R5
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB;
  logic [1:0]  opSel;
  logic        inValid, qClear;
  logic [31:0] result;
  logic        qSticky;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  sat_arith_unit #(.DATA_W(32)) dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .inValid(inValid), .qClear(qClear), .result(result), .qSticky(qSticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic v, input logic c);
    @(negedge clk);
    opSel = op; opA = a; opB = b; inValid = v; qClear = c;
  endtask

  initial begin
    rstN = 1'b0; opA = '0; opB = '0; opSel = 2'd0; inValid = 1'b0; qClear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset flag", {31'b0, qSticky}, 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(2'd0, 32'd0, 32'd0, 1'b0, 1'b1);          // clear flag
      drive(VEC[i].op, VEC[i].a, VEC[i].b, 1'b1, 1'b0);
      #1;
      check($sformatf("R1-R5 vec %0d result", i), result, VEC[i].exp);
      drive(2'd0, 32'd0, 32'd0, 1'b0, 1'b0);
      check($sformatf("R6 R11 vec %0d flag", i), {31'b0, qSticky}, {31'b0, VEC[i].ovf});
    end

    // R7: sticky across non-overflowing ops
    drive(2'd0, 32'd0, 32'd0, 1'b0, 1'b1);
    drive(2'd0, 32'h7FFFFFFF, 32'h00000005, 1'b1, 1'b0);
    drive(2'd0, 32'h00000001, 32'h00000001, 1'b1, 1'b0);
    check("R6 flag set", {31'b0, qSticky}, 32'd1);
    drive(2'd1, 32'h00000009, 32'h00000002, 1'b1, 1'b0);
    drive(2'd2, 32'h00000000, 32'h00000000, 1'b0, 1'b0);
    check("R7 flag sticky", {31'b0, qSticky}, 32'd1);

    // R8: clear wins over same-cycle set
    drive(2'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 1'b1);
    drive(2'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    check("R8 clear priority", {31'b0, qSticky}, 32'd0);

    // R9: overflow while not valid is ignored
    drive(2'd3, 32'h00000000, 32'h80000000, 1'b0, 1'b0);
    #1;
    check("R9 result still computed", result, 32'h7FFFFFFF);
    drive(2'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    check("R9 flag unchanged", {31'b0, qSticky}, 32'd0);

    // R10: reset clears a set flag
    drive(2'd1, 32'h80000000, 32'h7FFFFFFF, 1'b1, 1'b0);
    drive(2'd0, 32'd0, 32'd0, 1'b0, 1'b0);
    check("R6 flag set again", {31'b0, qSticky}, 32'd1);
    rstN = 1'b0;
    @(negedge clk);
    check("R10 reset clears flag", {31'b0, qSticky}, 32'd0);
    rstN = 1'b1;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule